// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address by reading descriptors from a two-level translation table in memory. A caller pulses a start input and supplies three values: the virtual address, the table base and a flag that enables tiny pages. The walker then issues one or two 32-bit word reads on a simple read port. Each read uses a request/grant handshake followed by a valid response, and only one read is ever in flight.

The first descriptor can end the walk in one of two ways: it can be a fault, or it can map a 1 MB section. Otherwise it points to a coarse or fine second-level table. A second descriptor then maps a large, small or tiny page. When the walk finishes, done pulses for one cycle. The physical address, the 2-bit cacheable/bufferable attribute, the 4-bit domain and the page kind are reported at that point. A translation fault and a memory error each have their own flag. All results hold their values until the next walk completes. The block does not cache translations or check permissions.

Top module: `ptw_walker`

## Requirements
- R1: During and after reset, before any start, done_o, busy_o, mem_req_o, xlat_fault_o and bus_fault_o are 0, and paddr_o, attr_o, kind_o and domain_o are 0.
- R2: The first read address is {tbase_i[31:14], vaddr_i[31:20], 2'b00}. A request holds its address until it is granted, and no new request is raised until the previous read has returned a response with mem_rvalid_i.
- R3: The first descriptor type in bits 1:0 is decoded as 0 = fault, 1 = coarse table, 2 = section, 3 = fine table. A section completes after one read, with paddr {d[31:20], va[19:0]}, attr d[3:2] and kind 0. A type-0 descriptor completes with xlat_fault_o = 1.
- R4: When tiny_en_i was 0 at start, a first descriptor of type 3 completes after one read with xlat_fault_o = 1.
- R5: The second read address is {d[31:10], va[19:12], 2'b00} for a coarse table and {d[31:12], va[19:10], 2'b00} for a fine table, where d is the first descriptor.
- R6: The second descriptor s is decoded by s[1:0]. A value of 0 is a fault (xlat_fault_o = 1). A value of 1 is a large page: paddr {s[31:16], va[15:0]}, kind 1. A value of 2 is a small page: paddr {s[31:12], va[11:0]}, kind 2. A value of 3 is a tiny page: paddr {s[31:10], va[9:0]}, kind 3. For every valid page, attr is s[3:2].
- R7: domain_o is bits 8:5 of the first descriptor whenever the first read returned without error. It is 0 when the first read errored.
- R8: A response with mem_err_i = 1 ends the walk with bus_fault_o = 1 and xlat_fault_o = 0. On any fault, paddr_o, attr_o and kind_o are 0, and the two fault flags are never both 1.
- R9: done_o is high for exactly the one cycle after the cycle in which the final response is sampled. All results keep their values until the next done.
- R10: A start while busy_o is 1 is ignored, including in the done cycle. busy_o rises only in the cycle after an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a walk (sampled only when idle) |
| vaddr_i | input | 32 | Virtual address to translate |
| tbase_i | input | 32 | Translation table base (low 14 bits ignored) |
| tiny_en_i | input | 1 | Tiny pages supported |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 32 | Word address of the read |
| mem_gnt_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 32 | Read data |
| mem_err_i | input | 1 | Read response is an error |
| busy_o | output | 1 | Walk in progress (includes done cycle) |
| done_o | output | 1 | One-cycle completion pulse |
| paddr_o | output | 32 | Physical address |
| attr_o | output | 2 | Cacheable/bufferable attribute |
| domain_o | output | 4 | Domain number |
| kind_o | output | 2 | Page kind: 0 section, 1 large, 2 small, 3 tiny |
| xlat_fault_o | output | 1 | Translation fault |
| bus_fault_o | output | 1 | Memory read error |

## Verification
The bench plays the memory itself and chooses the grant and response delays for each walk. It therefore knows the exact cycle in which the final response is sampled, and it expects done in the following cycle and in no other. On every clock the bench compares done against that prediction. Read addresses are checked in the cycle the grant is given. The bench also checks that no request is raised while a response is still owed. The results are compared in the done cycle and again four cycles later. An ignored start is shown by the absence of any request and by busy staying low in the cycles after it.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned TB_LSB   = 14;  // table base alignment
  localparam int unsigned SECT_LSB = 20;  // section / L1 index low bit
  localparam int unsigned CRS_LSB  = 10;  // coarse table base low bit
  localparam int unsigned FINE_LSB = 12;  // fine table base low bit
  localparam int unsigned LRG_LSB  = 16;
  localparam int unsigned SML_LSB  = 12;
  localparam int unsigned TINY_LSB = 10;
  localparam int unsigned DOM_LSB  = 5;
  localparam int unsigned DOM_W    = 4;
  localparam int unsigned ATTR_LSB = 2;
  localparam int unsigned ATTR_W   = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
  } walk_state_e;

  typedef enum logic [1:0] {
    PG_SECTION = 2'd0, PG_LARGE = 2'd1, PG_SMALL = 2'd2, PG_TINY = 2'd3
  } page_kind_e;

  typedef struct packed {
    logic [WORD_W-1:0] pa;
    logic [ATTR_W-1:0] attr;
    page_kind_e        kind;
    logic              fault;
  } page_res_t;
endpackage

// File: rtl/ptw_l1_decode.sv
module ptw_l1_decode
  import ptw_pkg::*;
(
  input  logic [WORD_W-1:0] desc_i,
  input  logic [WORD_W-1:0] va_i,
  input  logic              tiny_en_i,
  output logic              fault_o,
  output logic              section_o,
  output page_res_t         sect_o,
  output logic [DOM_W-1:0]  domain_o,
  output logic [WORD_W-1:0] l2_addr_o
);
  logic [1:0] ty;
  assign ty = desc_i[1:0];

  always_comb begin
    fault_o   = (ty == 2'd0) || (ty == 2'd3 && !tiny_en_i);
    section_o = (ty == 2'd2);
    domain_o  = desc_i[DOM_LSB +: DOM_W];
    sect_o.pa    = {desc_i[WORD_W-1:SECT_LSB], va_i[SECT_LSB-1:0]};
    sect_o.attr  = desc_i[ATTR_LSB +: ATTR_W];
    sect_o.kind  = PG_SECTION;
    sect_o.fault = 1'b0;
    if (ty == 2'd3)
      l2_addr_o = {desc_i[WORD_W-1:FINE_LSB], va_i[SECT_LSB-1:TINY_LSB], 2'b00};
    else
      l2_addr_o = {desc_i[WORD_W-1:CRS_LSB], va_i[SECT_LSB-1:SML_LSB], 2'b00};
  end
endmodule

// File: rtl/ptw_l2_decode.sv
module ptw_l2_decode
  import ptw_pkg::*;
(
  input  logic [WORD_W-1:0] desc_i,
  input  logic [WORD_W-1:0] va_i,
  output page_res_t         res_o
);
  always_comb begin
    res_o.attr  = desc_i[ATTR_LSB +: ATTR_W];
    res_o.fault = 1'b0;
    unique case (desc_i[1:0])
      2'd1: begin
        res_o.pa   = {desc_i[WORD_W-1:LRG_LSB], va_i[LRG_LSB-1:0]};
        res_o.kind = PG_LARGE;
      end
      2'd2: begin
        res_o.pa   = {desc_i[WORD_W-1:SML_LSB], va_i[SML_LSB-1:0]};
        res_o.kind = PG_SMALL;
      end
      2'd3: begin
        res_o.pa   = {desc_i[WORD_W-1:TINY_LSB], va_i[TINY_LSB-1:0]};
        res_o.kind = PG_TINY;
      end
      default: begin
        res_o.pa    = '0;
        res_o.kind  = PG_SECTION;
        res_o.fault = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] vaddr_i,
  input  logic [WORD_W-1:0] tbase_i,
  input  logic              tiny_en_i,
  output logic              mem_req_o,
  output logic [WORD_W-1:0] mem_addr_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              mem_err_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] paddr_o,
  output logic [ATTR_W-1:0] attr_o,
  output logic [DOM_W-1:0]  domain_o,
  output logic [1:0]        kind_o,
  output logic              xlat_fault_o,
  output logic              bus_fault_o
);
  walk_state_e state_q, state_d;
  logic [WORD_W-1:0] va_q, tb_q, l1_q;
  logic              tiny_q;

  logic [WORD_W-1:0] l1_desc, l1_addr, l2_addr;
  logic              l1_fault, l1_sect;
  logic [DOM_W-1:0]  l1_dom;
  page_res_t         sect_res, page_res;

  logic [WORD_W-1:0] pa_q;
  logic [ATTR_W-1:0] attr_q;
  logic [DOM_W-1:0]  dom_q;
  page_kind_e        kind_q;
  logic              xf_q, bf_q;

  // decode the live response during L1_WAIT, the stored descriptor afterwards
  assign l1_desc = (state_q == ST_L1_WAIT) ? mem_rdata_i : l1_q;
  assign l1_addr = {tb_q[WORD_W-1:TB_LSB], va_q[WORD_W-1:SECT_LSB], 2'b00};

  ptw_l1_decode i_l1_dec (
    .desc_i    (l1_desc),
    .va_i      (va_q),
    .tiny_en_i (tiny_q),
    .fault_o   (l1_fault),
    .section_o (l1_sect),
    .sect_o    (sect_res),
    .domain_o  (l1_dom),
    .l2_addr_o (l2_addr)
  );

  ptw_l2_decode i_l2_dec (
    .desc_i (mem_rdata_i),
    .va_i   (va_q),
    .res_o  (page_res)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_L1_REQ;
      ST_L1_REQ:  if (mem_gnt_i) state_d = ST_L1_WAIT;
      ST_L1_WAIT: if (mem_rvalid_i) begin
        if (mem_err_i || l1_fault || l1_sect) state_d = ST_DONE;
        else                                  state_d = ST_L2_REQ;
      end
      ST_L2_REQ:  if (mem_gnt_i) state_d = ST_L2_WAIT;
      ST_L2_WAIT: if (mem_rvalid_i) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      tb_q    <= '0;
      tiny_q  <= 1'b0;
      l1_q    <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) begin
        va_q   <= vaddr_i;
        tb_q   <= tbase_i;
        tiny_q <= tiny_en_i;
      end
      if (state_q == ST_L1_WAIT && mem_rvalid_i && !mem_err_i)
        l1_q <= mem_rdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pa_q   <= '0;
      attr_q <= '0;
      dom_q  <= '0;
      kind_q <= PG_SECTION;
      xf_q   <= 1'b0;
      bf_q   <= 1'b0;
    end else if (mem_rvalid_i && state_q == ST_L1_WAIT) begin
      if (mem_err_i) begin
        pa_q <= '0; attr_q <= '0; kind_q <= PG_SECTION; dom_q <= '0;
        xf_q <= 1'b0; bf_q <= 1'b1;
      end else if (l1_fault) begin
        pa_q <= '0; attr_q <= '0; kind_q <= PG_SECTION; dom_q <= l1_dom;
        xf_q <= 1'b1; bf_q <= 1'b0;
      end else if (l1_sect) begin
        pa_q <= sect_res.pa; attr_q <= sect_res.attr; kind_q <= sect_res.kind;
        dom_q <= l1_dom; xf_q <= 1'b0; bf_q <= 1'b0;
      end
    end else if (mem_rvalid_i && state_q == ST_L2_WAIT) begin
      dom_q <= l1_dom;
      if (mem_err_i || page_res.fault) begin
        pa_q <= '0; attr_q <= '0; kind_q <= PG_SECTION;
        xf_q <= !mem_err_i; bf_q <= mem_err_i;
      end else begin
        pa_q <= page_res.pa; attr_q <= page_res.attr; kind_q <= page_res.kind;
        xf_q <= 1'b0; bf_q <= 1'b0;
      end
    end
  end

  assign mem_req_o    = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
  assign mem_addr_o   = (state_q == ST_L2_REQ) ? l2_addr : l1_addr;
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = (state_q == ST_DONE);
  assign paddr_o      = pa_q;
  assign attr_o       = attr_q;
  assign domain_o     = dom_q;
  assign kind_o       = kind_q;
  assign xlat_fault_o = xf_q;
  assign bus_fault_o  = bf_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        mem_req_o,
  input logic [31:0] mem_addr_o,
  input logic        mem_gnt_i,
  input logic        busy_o,
  input logic        done_o,
  input logic [31:0] paddr_o,
  input logic [1:0]  attr_o,
  input logic [1:0]  kind_o,
  input logic        xlat_fault_o,
  input logic        bus_fault_o
);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($stable(paddr_o) && $stable(attr_o) && $stable(kind_o)) |-> done_o);
  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o)));
  // R10
  idle_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);
  // R10
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  // R8
  fault_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(xlat_fault_o && bus_fault_o));
  // R8
  fault_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (xlat_fault_o || bus_fault_o)) |-> (paddr_o == 32'd0 && kind_o == 2'd0 && attr_o == 2'd0));
endmodule

bind ptw_walker ptw_walker_chk i_ptw_walker_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_gnt_i    (mem_gnt_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .paddr_o      (paddr_o),
  .attr_o       (attr_o),
  .kind_o       (kind_o),
  .xlat_fault_o (xlat_fault_o),
  .bus_fault_o  (bus_fault_o)
);

// File: tb/test_ptw_walker.sv
`timescale 1ns/1ps
module test_ptw_walker;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        start_i = 1'b0, tiny_en_i = 1'b0;
  logic [31:0] vaddr_i = '0, tbase_i = '0;
  logic        mem_gnt_i = 1'b0, mem_rvalid_i = 1'b0, mem_err_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        mem_req_o, busy_o, done_o, xlat_fault_o, bus_fault_o;
  logic [31:0] mem_addr_o, paddr_o;
  logic [1:0]  attr_o, kind_o;
  logic [3:0]  domain_o;

  always #4 clk = ~clk;

  ptw_walker i_ptw_walker (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .vaddr_i(vaddr_i),
    .tbase_i(tbase_i), .tiny_en_i(tiny_en_i), .mem_req_o(mem_req_o),
    .mem_addr_o(mem_addr_o), .mem_gnt_i(mem_gnt_i), .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i(mem_rdata_i), .mem_err_i(mem_err_i), .busy_o(busy_o),
    .done_o(done_o), .paddr_o(paddr_o), .attr_o(attr_o), .domain_o(domain_o),
    .kind_o(kind_o), .xlat_fault_o(xlat_fault_o), .bus_fault_o(bus_fault_o)
  );

  int n_cmp = 0, n_bad = 0;
  bit [31:0] mem [bit [31:0]];

  logic [31:0] e_pa, e_addr0, e_addr1;
  logic [1:0]  e_attr, e_kind;
  logic [3:0]  e_dom;
  logic        e_xf, e_bf;
  int          e_nrd = 1, err_idx = -1, gnt_dly = 0, rsp_dly = 0;

  int phase = 0, gw = 0, rc = 0, rd_idx = 0;
  bit prev_final = 0;
  logic [31:0] gaddr = '0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mrd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'd0;
  endfunction

  function automatic logic [31:0] l1_at(logic [31:0] va, logic [31:0] tb);
    return (tb & 32'hFFFF_C000) | ((va >> 20) << 2);
  endfunction

  function automatic logic [31:0] l2_at(logic [31:0] d1, logic [31:0] va);
    if (d1[1:0] == 2'd1) return (d1 & 32'hFFFF_FC00) | (((va >> 12) & 32'hFF) << 2);
    return (d1 & 32'hFFFF_F000) | (((va >> 10) & 32'h3FF) << 2);
  endfunction

  task automatic predict(logic [31:0] va, logic [31:0] tb, bit tiny, int erri);
    logic [31:0] d1, d2;
    e_pa = '0; e_attr = '0; e_kind = '0; e_dom = '0; e_xf = 0; e_bf = 0;
    e_addr0 = l1_at(va, tb); e_addr1 = '0; e_nrd = 1;
    d1 = mrd(e_addr0);
    if (erri == 0) begin e_bf = 1; return; end
    e_dom = 4'((d1 >> 5) & 32'hF);
    if (d1[1:0] == 2'd0 || (d1[1:0] == 2'd3 && !tiny)) begin e_xf = 1; return; end
    if (d1[1:0] == 2'd2) begin
      e_pa = (d1 & 32'hFFF0_0000) | (va & 32'h000F_FFFF);
      e_attr = 2'((d1 >> 2) & 3);
      return;
    end
    e_addr1 = l2_at(d1, va); e_nrd = 2;
    if (erri == 1) begin e_bf = 1; return; end
    d2 = mrd(e_addr1);
    case (d2[1:0])
      2'd0: begin e_xf = 1; return; end
      2'd1: e_pa = (d2 & 32'hFFFF_0000) | (va & 32'h0000_FFFF);
      2'd2: e_pa = (d2 & 32'hFFFF_F000) | (va & 32'h0000_0FFF);
      default: e_pa = (d2 & 32'hFFFF_FC00) | (va & 32'h0000_03FF);
    endcase
    e_kind = d2[1:0];
    e_attr = 2'((d2 >> 2) & 3);
  endtask

  // memory responder and per-clock done comparison
  always @(negedge clk) begin
    if (!rst_ni) begin
      phase = 0; gw = 0; rc = 0; rd_idx = 0; prev_final = 0;
    end else begin
      chk("R9 done timing", 32'(done_o), 32'(prev_final));
      prev_final = 0;
      mem_rvalid_i = 0; mem_err_i = 0;
      if (phase != 0) chk("R2 one outstanding read", 32'(mem_req_o), 32'd0);
      case (phase)
        0: if (mem_req_o) begin
          if (gw >= gnt_dly) begin
            if (rd_idx == 0) chk("R2 first address", mem_addr_o, e_addr0);
            else             chk("R5 second address", mem_addr_o, e_addr1);
            chk("R3 read count", 32'(rd_idx < e_nrd), 32'd1);
            gaddr = mem_addr_o; mem_gnt_i = 1; phase = 1;
          end else gw++;
        end
        1: begin mem_gnt_i = 0; phase = 2; rc = 0; end
        default: ;
      endcase
      if (phase == 2) begin
        if (rc >= rsp_dly) begin
          mem_rvalid_i = 1;
          mem_rdata_i = mrd(gaddr);
          mem_err_i = (err_idx == rd_idx);
          prev_final = mem_err_i || (rd_idx + 1 >= e_nrd);
          rd_idx = prev_final ? 0 : rd_idx + 1;
          phase = 0; gw = 0;
        end else rc++;
      end
    end
  end

  task automatic cmp_out(string tag);
    chk({tag, " paddr"}, paddr_o, e_pa);
    chk({tag, " attr"}, 32'(attr_o), 32'(e_attr));
    chk({tag, " kind"}, 32'(kind_o), 32'(e_kind));
    chk({tag, " domain R7"}, 32'(domain_o), 32'(e_dom));
    chk({tag, " xlat_fault"}, 32'(xlat_fault_o), 32'(e_xf));
    chk({tag, " bus_fault R8"}, 32'(bus_fault_o), 32'(e_bf));
  endtask

  task automatic wait_done(string tag);
    int k = 0;
    while (!done_o && k < 200) begin @(negedge clk); k++; end
    if (!done_o) chk({tag, " R9 no done"}, 0, 1);
  endtask

  task automatic kick(logic [31:0] va, logic [31:0] tb, bit tiny);
    @(negedge clk);
    start_i = 1; vaddr_i = va; tbase_i = tb; tiny_en_i = tiny;
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic run(logic [31:0] va, logic [31:0] tb, bit tiny, int erri,
                     int gd, int rd, string tag);
    predict(va, tb, tiny, erri);
    err_idx = erri; gnt_dly = gd; rsp_dly = rd;
    kick(va, tb, tiny);
    wait_done(tag);
    cmp_out(tag);
  endtask

  localparam logic [31:0] TB = 32'h0004_1ABC;

  initial begin
    repeat (1000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    // section
    mem[l1_at(32'h1230_0456, TB)] = 32'hABC0_0000 | (5 << 5) | (2 << 2) | 2;
    // coarse table shared by large/small/fault walks
    d = 32'h0008_0400 | (9 << 5) | 1;
    mem[l1_at(32'h0050_7A12, TB)] = d;
    mem[l2_at(d, 32'h0050_7A12)] = 32'h5555_0000 | (1 << 2) | 1;
    mem[l2_at(d, 32'h0050_3FFF)] = 32'h7777_7000 | (3 << 2) | 2;
    // fine table
    d = 32'h0009_0000 | (3 << 5) | 3;
    mem[l1_at(32'h0061_2345, TB)] = d;
    mem[l2_at(d, 32'h0061_2345)] = 32'h1234_5400 | (1 << 2) | 3;
    mem[l2_at(d, 32'h0061_0800)] = 32'h0ABC_D000 | 2;

    repeat (2) @(negedge clk);
    chk("R1 reset done", 32'(done_o), 0);
    chk("R1 reset busy", 32'(busy_o), 0);
    chk("R1 reset req", 32'(mem_req_o), 0);
    rst_ni = 1;
    @(negedge clk);
    e_pa = 0; e_attr = 0; e_kind = 0; e_dom = 0; e_xf = 0; e_bf = 0;
    cmp_out("R1 after reset");

    run(32'h1230_0456, TB, 0, -1, 0, 0, "R3 section");
    repeat (4) @(negedge clk);
    cmp_out("R9 hold");
    run(32'h0050_7A12, TB, 0, -1, 2, 1, "R5 R6 coarse large");
    run(32'h0050_3FFF, TB, 0, -1, 0, 3, "R6 coarse small");
    run(32'h0061_2345, TB, 1, -1, 1, 0, "R6 fine tiny");
    run(32'h0061_0800, TB, 1, -1, 3, 2, "R6 fine small");
    run(32'h0061_2345, TB, 0, -1, 0, 1, "R4 tiny disabled");
    run(32'hFFF0_0000, TB, 0, -1, 1, 1, "R3 first fault");
    run(32'h0050_1000, TB, 0, -1, 0, 0, "R6 second fault");
    run(32'h1230_0456, TB, 0, 0, 2, 2, "R8 first bus error");
    run(32'h0050_7A12, TB, 0, 1, 0, 2, "R8 second bus error");

    // R10: start during the walk is ignored
    predict(32'h0050_7A12, TB, 0, -1);
    err_idx = -1; gnt_dly = 2; rsp_dly = 3;
    kick(32'h0050_7A12, TB, 0);
    @(negedge clk);
    start_i = 1; vaddr_i = 32'h1230_0456;
    @(negedge clk);
    start_i = 0;
    wait_done("R10 busy start");
    cmp_out("R10 busy start");
    // R10: start in the done cycle is ignored
    start_i = 1; vaddr_i = 32'h1230_0456;
    @(negedge clk);
    start_i = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R10 no request after done-cycle start", 32'(mem_req_o), 0);
      chk("R10 idle after done-cycle start", 32'(busy_o), 0);
    end
    cmp_out("R9 R10 hold after ignored start");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule